// File: doc/BRIEF.md
# Single-Buffer Serial Channel Status and Data Registers

This block holds the flag and byte-buffer state of a simple asynchronous serial channel. The channel has one transmit holding byte and one receive holding byte. Software reaches the block through a byte-wide register port with a single-cycle valid strobe. A line receiver delivers complete bytes on a strobe. A transmit shifter takes the pending byte through a valid/ready handshake. The block also stores the mode, bit-rate and control bytes that the shifters use.

Status flags are cleared with a write-zero-after-read discipline. A zero written to a flag clears it only if an earlier status read showed that flag as one. This stops software from wiping out an event it has not yet seen. The transmit-end flag is tied to the transmit-empty flag and can never be set while the buffer is full. While the transmitter is disabled, both transmit flags are held set.

Register offsets are 0 for mode, 1 for bit rate, 2 for control, 3 for transmit data, 4 for status and 5 for receive data. Status bits are: 7 transmit buffer empty, 6 receive buffer full, 5 overrun, 4 framing error, 3 parity error, 2 transmit end, 1 multiprocessor-in (always 0) and 0 multiprocessor-out. Control bit 5 is transmit enable and control bit 4 is receive enable.

Top module: `serial_flag_regs`

## Requirements
- R1: After reset, status reads 0x84, control reads 0x00, mode reads 0x00, bit rate reads 0xFF and tx_valid is low.
- R2: Mode (offset 0) and bit rate (offset 1) store written bytes and read them back. Read data appears on reg_rdata at the clock edge that ends the read cycle.
- R3: A receive strobe while control bit 4 is set and status bit 6 is clear stores rx_byte and sets bit 6, and reading offset 5 returns that byte. While control bit 4 is clear the strobe is ignored.
- R4: A receive strobe while status bit 6 is already set drops the byte, sets overrun (bit 5) and keeps the held byte.
- R5: Reading offset 5 clears status bit 6. A byte that arrives in the same cycle as that read is stored without overrun, and bit 6 stays set.
- R6: A zero written to status bit 7..2 clears that flag only if the latest status read showed it as one. Writing a one never sets any of bits 7..3.
- R7: Status bit 1 always reads 0.
- R8: Whenever transmit-empty (bit 7) is zero, transmit-end (bit 2) is also zero, and a status write that clears bit 7 clears bit 2 in the same update.
- R9: In the cycle after control bit 5 is seen clear, status bits 7 and 2 are both set.
- R10: Writing offset 3 clears bit 2. While bit 7 is clear, tx_valid is high with the written byte on tx_byte. A cycle with tx_ready high sets bits 7 and 2 and drops tx_valid.
- R11: A status write copies written bit 0 into status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe, one cycle per access |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| rx_strobe | input | 1 | A complete byte from the line receiver |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Transmit byte pending for the shifter |
| tx_byte | output | 8 | Transmit byte |
| tx_ready | input | 1 | Shifter accepts the pending byte |
| cfg_mode | output | 8 | Mode byte for the shifters |
| cfg_rate | output | 8 | Bit-rate byte for the shifters |
| cfg_ctrl | output | 8 | Control byte (bit 5 transmit enable, bit 4 receive enable) |

## Verification
A wrong read-record bit shows up one status write later. A flag either survives a zero write after it was shown, or vanishes before it was ever read, and the next status read reveals it. A wrong receive-full flag shows on the very next strobe: a good byte is counted as overrun, or a held byte is overwritten, which a read of offset 5 exposes. A broken transmit flag is visible on tx_valid in the cycle after the status write, and on the status bits in the cycle after the handshake.

// File: rtl/sfr_pkg.sv
// Shared offsets, status and control bit positions, and the decoded access
// record for the serial flag register block.
package sfr_pkg;

    localparam int unsigned BYTE_W = 8;

    // register byte offsets
    localparam int unsigned OFS_MODE = 0;
    localparam int unsigned OFS_RATE = 1;
    localparam int unsigned OFS_CTRL = 2;
    localparam int unsigned OFS_TXD  = 3;
    localparam int unsigned OFS_STAT = 4;
    localparam int unsigned OFS_RXD  = 5;

    // status bit positions (software decodes these)
    localparam int unsigned ST_TXE    = 7;
    localparam int unsigned ST_RXF    = 6;
    localparam int unsigned ST_OVR    = 5;
    localparam int unsigned ST_FRM    = 4;
    localparam int unsigned ST_PAR    = 3;
    localparam int unsigned ST_TXDONE = 2;
    localparam int unsigned ST_MPIN   = 1;
    localparam int unsigned ST_MPOUT  = 0;

    // control bit positions
    localparam int unsigned CT_TXEN = 5;
    localparam int unsigned CT_RXEN = 4;

    localparam logic [BYTE_W-1:0] ST_RESET   = 8'h84;
    localparam logic [BYTE_W-1:0] RATE_RESET = 8'hFF;
    localparam logic [BYTE_W-1:0] TXD_RESET  = 8'hFF;

    // one-hot decoded register access for the current cycle
    typedef struct packed {
        logic wr_mode;
        logic wr_rate;
        logic wr_ctrl;
        logic wr_txd;
        logic wr_stat;
        logic rd_stat;
        logic rd_rxd;
        logic rd_any;
    } sfr_acc_t;

endpackage

// File: rtl/sfr_decode.sv
// Decodes one register access strobe into per-register write and read
// events. Assumes at most one access per cycle; offsets with no register
// decode to nothing except rd_any.
module sfr_decode #(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    output sfr_pkg::sfr_acc_t acc
);
    import sfr_pkg::*;

    // combinational decode of the access into register events
    always_comb begin
        acc = '0;
        acc.rd_any = reg_valid && !reg_write;
        if (reg_valid) begin
            if (reg_write) begin
                acc.wr_mode = (reg_addr == ADDR_W'(OFS_MODE));
                acc.wr_rate = (reg_addr == ADDR_W'(OFS_RATE));
                acc.wr_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
                acc.wr_txd  = (reg_addr == ADDR_W'(OFS_TXD));
                acc.wr_stat = (reg_addr == ADDR_W'(OFS_STAT));
            end else begin
                acc.rd_stat = (reg_addr == ADDR_W'(OFS_STAT));
                acc.rd_rxd  = (reg_addr == ADDR_W'(OFS_RXD));
            end
        end
    end

endmodule

// File: rtl/sfr_cfg_regs.sv
// Holds the plain storage bytes: mode, bit rate, control and the transmit
// holding byte. These have no side effects of their own; flag effects of a
// transmit-data write are handled in the flag logic.
module sfr_cfg_regs (
    input  logic                       clk,
    input  logic                       rst_n,
    input  sfr_pkg::sfr_acc_t          acc,
    input  logic [sfr_pkg::BYTE_W-1:0] wdata,
    output logic [sfr_pkg::BYTE_W-1:0] mode_q,
    output logic [sfr_pkg::BYTE_W-1:0] rate_q,
    output logic [sfr_pkg::BYTE_W-1:0] ctrl_q,
    output logic [sfr_pkg::BYTE_W-1:0] txd_q
);
    import sfr_pkg::*;

    // load each storage byte on its own write event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            rate_q <= RATE_RESET;
            ctrl_q <= '0;
            txd_q  <= TXD_RESET;
        end else begin
            if (acc.wr_mode) mode_q <= wdata;
            if (acc.wr_rate) rate_q <= wdata;
            if (acc.wr_ctrl) ctrl_q <= wdata;
            if (acc.wr_txd)  txd_q  <= wdata;
        end
    end

endmodule

// File: rtl/sfr_flags.sv
// Status flag engine. Keeps the flag byte and a record of which flags the
// latest status read showed as one. A written zero clears only recorded
// flags. Receive events set full or overrun, the shifter handshake sets
// both transmit flags, and a disabled transmitter pins them set.
// Assumes a single register access per cycle.
module sfr_flags (
    input  logic                       clk,
    input  logic                       rst_n,
    input  sfr_pkg::sfr_acc_t          acc,
    input  logic [sfr_pkg::BYTE_W-1:0] wdata,
    input  logic                       tx_en,
    input  logic                       rx_en,
    input  logic                       rx_strobe,
    input  logic                       tx_ready,
    output logic [sfr_pkg::BYTE_W-1:0] stat_q,
    output logic                       rx_store
);
    import sfr_pkg::*;

    logic [BYTE_W-1:0] seen_q;
    logic [BYTE_W-1:0] stat_d;
    logic [BYTE_W-1:0] seen_d;
    logic [BYTE_W-1:0] kept;
    logic              rx_full_eff;
    logic              rx_hit;
    logic              tx_take;

    // a read of the receive byte in this cycle frees the buffer for arrivals
    assign rx_full_eff = stat_q[ST_RXF] && !acc.rd_rxd;
    assign rx_hit      = rx_strobe && rx_en;
    assign rx_store    = rx_hit && !rx_full_eff;
    assign tx_take     = !stat_q[ST_TXE] && tx_ready;
    assign kept        = stat_q & (wdata | ~seen_q);

    // next flag byte and read record, applied in priority order
    always_comb begin
        stat_d = stat_q;
        seen_d = seen_q;
        if (acc.wr_stat) begin
            stat_d[ST_TXE:ST_TXDONE] = kept[ST_TXE:ST_TXDONE];
            stat_d[ST_MPOUT]         = wdata[ST_MPOUT];
            seen_d                   = seen_q & wdata;
        end
        if (acc.rd_stat) begin
            seen_d = stat_q;
        end
        if (acc.rd_rxd) begin
            stat_d[ST_RXF] = 1'b0;
        end
        if (rx_hit) begin
            if (rx_full_eff) stat_d[ST_OVR] = 1'b1;
            else             stat_d[ST_RXF] = 1'b1;
        end
        if (tx_take) begin
            stat_d[ST_TXE]    = 1'b1;
            stat_d[ST_TXDONE] = 1'b1;
        end
        if (acc.wr_txd) begin
            stat_d[ST_TXDONE] = 1'b0;
        end
        if (!stat_d[ST_TXE]) begin
            stat_d[ST_TXDONE] = 1'b0;
        end
        if (!tx_en) begin
            stat_d[ST_TXE]    = 1'b1;
            stat_d[ST_TXDONE] = 1'b1;
        end
        stat_d[ST_MPIN] = 1'b0;
    end

    // flag and read-record registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= ST_RESET;
            seen_q <= '0;
        end else begin
            stat_q <= stat_d;
            seen_q <= seen_d;
        end
    end

endmodule

// File: rtl/sfr_rx_buffer.sv
// Single receive holding byte, loaded when the flag engine accepts an
// arriving byte. Assumes the store decision already covers enable, full
// and overrun.
module sfr_rx_buffer (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_store,
    input  logic [sfr_pkg::BYTE_W-1:0] rx_byte,
    output logic [sfr_pkg::BYTE_W-1:0] rx_data_q
);
    // capture an accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) rx_data_q <= '0;
        else if (rx_store) rx_data_q <= rx_byte;
    end

endmodule

// File: rtl/serial_flag_regs.sv
// Top of the single-buffer serial channel register block. Ties the access
// decoder, storage bytes, flag engine and receive buffer together, and
// registers the read data. Assumes one access per cycle on the register
// port; unmapped offsets read zero and ignore writes.
module serial_flag_regs #(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              rx_strobe,
    input  logic [7:0]        rx_byte,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_ready,
    output logic [7:0]        cfg_mode,
    output logic [7:0]        cfg_rate,
    output logic [7:0]        cfg_ctrl
);
    import sfr_pkg::*;

    sfr_acc_t          acc;
    logic [BYTE_W-1:0] stat_q;
    logic [BYTE_W-1:0] rx_data_q;
    logic [BYTE_W-1:0] txd_q;
    logic [BYTE_W-1:0] rd_mux;
    logic              rx_store;

    sfr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .acc       (acc)
    );

    sfr_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .wdata  (reg_wdata),
        .mode_q (cfg_mode),
        .rate_q (cfg_rate),
        .ctrl_q (cfg_ctrl),
        .txd_q  (txd_q)
    );

    sfr_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .wdata     (reg_wdata),
        .tx_en     (cfg_ctrl[CT_TXEN]),
        .rx_en     (cfg_ctrl[CT_RXEN]),
        .rx_strobe (rx_strobe),
        .tx_ready  (tx_ready),
        .stat_q    (stat_q),
        .rx_store  (rx_store)
    );

    sfr_rx_buffer u_rxb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_store  (rx_store),
        .rx_byte   (rx_byte),
        .rx_data_q (rx_data_q)
    );

    assign tx_valid = !stat_q[ST_TXE];
    assign tx_byte  = txd_q;

    // select the register addressed by a read
    always_comb begin
        unique case (reg_addr)
            ADDR_W'(OFS_MODE): rd_mux = cfg_mode;
            ADDR_W'(OFS_RATE): rd_mux = cfg_rate;
            ADDR_W'(OFS_CTRL): rd_mux = cfg_ctrl;
            ADDR_W'(OFS_TXD):  rd_mux = txd_q;
            ADDR_W'(OFS_STAT): rd_mux = stat_q;
            ADDR_W'(OFS_RXD):  rd_mux = rx_data_q;
            default:           rd_mux = '0;
        endcase
    end

    // register read data at the end of the read cycle
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else if (acc.rd_any) reg_rdata <= rd_mux;
    end

endmodule

// File: rtl/serial_flag_regs_chk.sv
// Property checker for serial_flag_regs, attached by bind. It observes
// ports plus the flag byte and the receive holding byte.
module serial_flag_regs_chk #(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              rx_strobe,
    input logic [7:0]        rx_byte,
    input logic              tx_ready,
    input logic              tx_valid,
    input logic [7:0]        cfg_ctrl,
    input logic [7:0]        stat,
    input logic [7:0]        rxbuf
);
    // R3
    rx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe && cfg_ctrl[4] && !stat[6] |=> stat[6] && rxbuf == $past(rx_byte));

    // R4
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe && cfg_ctrl[4] && stat[6] && !(reg_valid && !reg_write && reg_addr == ADDR_W'(5))
        |=> stat[5] && rxbuf == $past(rxbuf));

    // R6
    no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && reg_write && reg_addr == ADDR_W'(4) && !stat[5] && !rx_strobe |=> !stat[5]);

    // R8
    tend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[2] |-> stat[7]);

    // R9
    tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ctrl[5] |=> stat[7] && stat[2]);

    // R10
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && !(reg_valid && reg_write && reg_addr == ADDR_W'(3))
        |=> !tx_valid && stat[2]);

    // R7
    mpin_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat[1]);

endmodule

bind serial_flag_regs serial_flag_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .rx_strobe (rx_strobe),
    .rx_byte   (rx_byte),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .cfg_ctrl  (cfg_ctrl),
    .stat      (stat_q),
    .rxbuf     (rx_data_q)
);

// File: tb/serial_flag_regs_test.sv
`timescale 1ns/1ps
module serial_flag_regs_test;
    localparam int unsigned ADDR_W = 3;
    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_S = 2'd2;
    localparam int NVEC = 38;

    // {op, addr, data-or-expected}
    localparam logic [12:0] VEC [NVEC] = '{
        {OP_R, 3'd4, 8'h84},  // 0  R1 status reset
        {OP_R, 3'd2, 8'h00},  // 1  R1 control reset
        {OP_R, 3'd1, 8'hFF},  // 2  R1 rate reset
        {OP_R, 3'd0, 8'h00},  // 3  R1 mode reset
        {OP_W, 3'd0, 8'h5A},  // 4  R2
        {OP_R, 3'd0, 8'h5A},  // 5  R2
        {OP_W, 3'd1, 8'h12},  // 6  R2
        {OP_R, 3'd1, 8'h12},  // 7  R2
        {OP_S, 3'd0, 8'h33},  // 8  R3 receiver off
        {OP_R, 3'd4, 8'h84},  // 9  R3 ignored
        {OP_R, 3'd5, 8'h00},  // 10 R3 buffer untouched
        {OP_W, 3'd2, 8'h10},  // 11 R3 receiver on
        {OP_S, 3'd0, 8'h41},  // 12
        {OP_R, 3'd4, 8'hC4},  // 13 R3 full set
        {OP_R, 3'd5, 8'h41},  // 14 R3 byte stored
        {OP_R, 3'd4, 8'h84},  // 15 R5 full cleared by read
        {OP_S, 3'd0, 8'h52},  // 16
        {OP_S, 3'd0, 8'h63},  // 17 R4 overrun
        {OP_R, 3'd4, 8'hE4},  // 18 R4
        {OP_R, 3'd5, 8'h52},  // 19 R4 first byte kept
        {OP_W, 3'd4, 8'h00},  // 20 R6 clear seen flags
        {OP_R, 3'd4, 8'h84},  // 21 R6
        {OP_S, 3'd0, 8'h70},  // 22
        {OP_S, 3'd0, 8'h71},  // 23
        {OP_W, 3'd4, 8'h00},  // 24 R6 unseen flags kept
        {OP_R, 3'd4, 8'hE4},  // 25 R6
        {OP_W, 3'd4, 8'hFF},  // 26 R11 ones set nothing
        {OP_R, 3'd4, 8'hE5},  // 27 R11 R7
        {OP_W, 3'd4, 8'hDF},  // 28 R6 clear overrun only
        {OP_R, 3'd4, 8'hC5},  // 29 R6
        {OP_W, 3'd4, 8'h00},  // 30 R6
        {OP_R, 3'd4, 8'h84},  // 31 R6
        {OP_W, 3'd2, 8'h30},  // 32 transmitter on
        {OP_R, 3'd4, 8'h84},  // 33
        {OP_W, 3'd4, 8'h7F},  // 34 R8 clear empty
        {OP_R, 3'd4, 8'h01},  // 35 R8 end cleared with empty
        {OP_W, 3'd2, 8'h10},  // 36 R9 transmitter off
        {OP_R, 3'd4, 8'h85}   // 37 R9 forced set
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_valid = 1'b0;
    logic              reg_write = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              rx_strobe = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic              tx_valid;
    logic [7:0]        tx_byte;
    logic              tx_ready = 1'b0;
    logic [7:0]        cfg_mode;
    logic [7:0]        cfg_rate;
    logic [7:0]        cfg_ctrl;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_flag_regs #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_ready(tx_ready), .cfg_mode(cfg_mode),
        .cfg_rate(cfg_rate), .cfg_ctrl(cfg_ctrl)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one access or strobe, driven at a falling edge, results sampled at the next
    task automatic do_op(input logic [1:0] op, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        if (op == OP_S) begin
            rx_strobe = 1'b1; rx_byte = d;
        end else begin
            reg_valid = 1'b1; reg_write = (op == OP_W); reg_addr = a; reg_wdata = d;
        end
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; rx_strobe = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [2:0] a, input logic [7:0] exp);
        do_op(OP_R, a, 8'h00);
        check(tag, reg_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            op = VEC[i][12:11];
            if (op == OP_R) begin
                rd_check($sformatf("vector %0d", i), VEC[i][10:8], VEC[i][7:0]);
            end else begin
                do_op(op, VEC[i][10:8], VEC[i][7:0]);
            end
        end

        // R10 transmit path and shifter handshake
        do_op(OP_W, 3'd2, 8'h30);
        rd_check("R10 before load", 3'd4, 8'h85);
        do_op(OP_W, 3'd3, 8'hA5);
        rd_check("R10 end cleared by data write", 3'd4, 8'h81);
        do_op(OP_W, 3'd4, 8'h7E);
        check("R10 tx_valid", {7'd0, tx_valid}, 8'h01);
        check("R10 tx_byte", tx_byte, 8'hA5);
        repeat (3) @(negedge clk);
        check("R10 tx_valid held", {7'd0, tx_valid}, 8'h01);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        check("R10 tx_valid dropped", {7'd0, tx_valid}, 8'h00);
        rd_check("R10 flags set after handoff", 3'd4, 8'h84);

        // R5 arrival in the same cycle as the receive-data read
        do_op(OP_S, 3'd0, 8'h11);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 3'd5;
        rx_strobe = 1'b1; rx_byte = 8'h22;
        @(negedge clk);
        reg_valid = 1'b0; rx_strobe = 1'b0;
        check("R5 old byte returned", reg_rdata, 8'h11);
        rd_check("R5 full kept no overrun", 3'd4, 8'hC4);
        rd_check("R5 new byte stored", 3'd5, 8'h22);

        // R1 reset mid-run
        do_op(OP_W, 3'd2, 8'h30);
        do_op(OP_W, 3'd4, 8'h00);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1 tx_valid after reset", {7'd0, tx_valid}, 8'h00);
        rd_check("R1 status after reset", 3'd4, 8'h84);
        rd_check("R1 control after reset", 3'd2, 8'h00);
        rd_check("R1 rate after reset", 3'd1, 8'hFF);

        finish_run();
    end
endmodule